// File: doc/BRIEF.md
# Cumulative-Scan Descriptor Legality Checker

This block judges whether a 64-byte instruction descriptor for a single-tensor inclusive prefix scan is legal. The whole descriptor is presented in parallel on a 512-bit bus together with a one-cycle strobe. Byte k of the descriptor sits on bits [8k+7:8k].

The checker reads a handful of fixed-position fields: the opcode class, the combining operator, the two element-type codes, the lane count, the scan axis and the control bytes that must be zero. It applies the rules for each opcode class. The same operator byte is judged against a different legal set depending on whether the descriptor is of the arithmetic or the bitwise class, and the bitwise class narrows the allowed element types further.

One clock edge after the strobe, a registered accept flag and a 3-bit cause code appear. The cause code names the first rule that failed. Both outputs hold until the next strobe. Memory patterns, event fields and any header content other than the opcode byte are not examined.

Top module: `scan_desc_check`

## Requirements
- R1: Byte 0 must be 0x4E (arithmetic class) or 0x5E (bitwise class). Any other value gives cause code 1.
- R2: Byte 35 (negate), byte 38 (mask enable) and bytes 39 to 43 (reserved) must all be zero. Otherwise the cause code is 2.
- R3: The input type (byte 32) must be one of 0x2–0xA or 0xD–0xF. The output type (byte 33) may be any of those or 0xB. The codes 0x0, 0x1, 0xC and anything above 0xF are rejected on either side. A violation gives cause code 3.
- R4: In the bitwise class the input type must equal the output type and must be 0x3, 0x5, 0x8 or 0x9. Otherwise the cause code is 3.
- R5: In the arithmetic class, byte 36 is legal when it is 0x00–0x19 except 0x07, or 0x1D, or 0xC4–0xC8. Every other value, including 0x07, 0x1A, 0x1B and 0x1C, gives cause code 4.
- R6: In the bitwise class, byte 36 is legal only when it is 0x00, 0x1C or 0x20–0x27. Every other value, including 0x07, 0x1A and 0x1B, gives cause code 4.
- R7: In the bitwise class, the logical right shift (0x24) is legal only when the type is 0x8 (INT32). With any other type it gives cause code 4.
- R8: Byte 34 (active lanes) must lie in 1..128. Otherwise the cause code is 5.
- R9: Byte 37 (scan axis) must be 0, 1, 2 or 3. Otherwise the cause code is 6.
- R10: When several rules fail, the cause code reports only the first failure, in this order: R1, R2, R3/R4, R5/R6/R7, R8, R9.
- R11: Accept and cause are registered. They change only on the clock edge that samples the strobe and hold while no strobe is present. Accept is 1 exactly when the cause code is 0. Reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Strobe: the descriptor on desc_data is to be judged |
| desc_data | input | 512 | Descriptor, byte k on bits [8k+7:8k] |
| accept | output | 1 | Registered verdict: 1 when the descriptor is legal |
| err_code | output | 3 | Registered cause of the first failing rule, 0 when legal |

## Verification
Several rule checks run on the same descriptor in the same cycle, so two failures can land in the same strobe. Examples are a bad opcode together with a non-zero reserved byte, or a forbidden operator together with a zero lane count. The bench builds such double-fault descriptors and checks that only the higher-priority cause is reported. It also checks that an otherwise clean descriptor then reports the lower-priority cause alone.

// File: rtl/scan_chk_pkg.sv
`timescale 1ns/1ps
package scan_chk_pkg;
    localparam int DESC_BYTES = 64;
    localparam int DESC_W     = DESC_BYTES * 8;

    localparam int OFF_OPC    = 0;
    localparam int OFF_DTIN   = 32;
    localparam int OFF_DTOUT  = 33;
    localparam int OFF_LANES  = 34;
    localparam int OFF_NEG    = 35;
    localparam int OFF_OPER   = 36;
    localparam int OFF_AXIS   = 37;
    localparam int OFF_MASK   = 38;
    localparam int OFF_RSV    = 39;
    localparam int RSV_BYTES  = 5;

    localparam logic [7:0] OPC_ARITH = 8'h4E;
    localparam logic [7:0] OPC_BITW  = 8'h5E;
    localparam logic [7:0] OPER_LSR  = 8'h24;
    localparam logic [7:0] DT_I32    = 8'h08;
    localparam int         MAX_LANES = 128;
    localparam int         AXIS_CNT  = 4;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_OPC   = 3'd1,
        CAUSE_ZERO  = 3'd2,
        CAUSE_DTYPE = 3'd3,
        CAUSE_OPER  = 3'd4,
        CAUSE_LANES = 3'd5,
        CAUSE_AXIS  = 3'd6
    } cause_e;

    typedef struct packed {
        logic   accept;
        cause_e cause;
    } verdict_t;
endpackage

// File: rtl/scan_dtype_gate.sv
`timescale 1ns/1ps
module scan_dtype_gate #(
    parameter bit ALLOW_OUT_ONLY = 1'b0
) (
    input  logic [7:0] code,
    output logic       ok
);
    always_comb begin
        ok = (code >= 8'h02) && (code <= 8'h0F) && (code != 8'h0C);
        if (!ALLOW_OUT_ONLY && code == 8'h0B) ok = 1'b0;
    end
endmodule

// File: rtl/scan_class_dtype.sv
`timescale 1ns/1ps
module scan_class_dtype (
    input  logic       is_bitw,
    input  logic [7:0] dt_in,
    input  logic [7:0] dt_out,
    output logic       ok
);
    logic narrow_ok;
    always_comb begin
        narrow_ok = (dt_in == dt_out) &&
                    (dt_in == 8'h03 || dt_in == 8'h05 ||
                     dt_in == 8'h08 || dt_in == 8'h09);
        ok = !is_bitw || narrow_ok;
    end
endmodule

// File: rtl/scan_oper_gate.sv
`timescale 1ns/1ps
module scan_oper_gate
    import scan_chk_pkg::*;
(
    input  logic       is_bitw,
    input  logic [7:0] oper,
    input  logic [7:0] dt_in,
    output logic       ok
);
    logic arith_ok;
    logic bitw_ok;
    always_comb begin
        arith_ok = ((oper <= 8'h19) && (oper != 8'h07)) ||
                   (oper == 8'h1D) ||
                   ((oper >= 8'hC4) && (oper <= 8'hC8));
        bitw_ok  = (oper == 8'h00) || (oper == 8'h1C) ||
                   ((oper >= 8'h20) && (oper <= 8'h27));
        if (oper == OPER_LSR && dt_in != DT_I32) bitw_ok = 1'b0;
        ok = is_bitw ? bitw_ok : arith_ok;
    end
endmodule

// File: rtl/scan_desc_check.sv
`timescale 1ns/1ps
module scan_desc_check
    import scan_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [DESC_W-1:0] desc_data,
    output logic              accept,
    output logic [2:0]        err_code
);
    function automatic logic [7:0] byte_at(input logic [DESC_W-1:0] d, input int idx);
        return d[idx*8 +: 8];
    endfunction

    logic [7:0] opc, dt_in, dt_out, lanes, neg, oper, axis, mask;
    logic       is_bitw, opc_ok, zero_ok, lanes_ok, axis_ok;
    logic [RSV_BYTES-1:0] rsv_clean;
    logic [1:0] dt_gen_ok;
    logic       dt_cls_ok, oper_ok;

    always_comb begin
        opc    = byte_at(desc_data, OFF_OPC);
        dt_in  = byte_at(desc_data, OFF_DTIN);
        dt_out = byte_at(desc_data, OFF_DTOUT);
        lanes  = byte_at(desc_data, OFF_LANES);
        neg    = byte_at(desc_data, OFF_NEG);
        oper   = byte_at(desc_data, OFF_OPER);
        axis   = byte_at(desc_data, OFF_AXIS);
        mask   = byte_at(desc_data, OFF_MASK);
    end

    generate
        for (genvar g = 0; g < RSV_BYTES; g++) begin : g_rsv
            assign rsv_clean[g] = (desc_data[(OFF_RSV+g)*8 +: 8] == 8'h00);
        end
        for (genvar s = 0; s < 2; s++) begin : g_dt
            scan_dtype_gate #(.ALLOW_OUT_ONLY(s == 1)) u_gate (
                .code (s == 0 ? dt_in : dt_out),
                .ok   (dt_gen_ok[s])
            );
        end
    endgenerate

    always_comb begin
        opc_ok   = (opc == OPC_ARITH) || (opc == OPC_BITW);
        is_bitw  = (opc == OPC_BITW);
        zero_ok  = (neg == 8'h00) && (mask == 8'h00) && (&rsv_clean);
        lanes_ok = (lanes != 8'h00) && (int'(lanes) <= MAX_LANES);
        axis_ok  = (int'(axis) < AXIS_CNT);
    end

    scan_class_dtype u_cls (
        .is_bitw (is_bitw),
        .dt_in   (dt_in),
        .dt_out  (dt_out),
        .ok      (dt_cls_ok)
    );

    scan_oper_gate u_oper (
        .is_bitw (is_bitw),
        .oper    (oper),
        .dt_in   (dt_in),
        .ok      (oper_ok)
    );

    verdict_t v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (desc_valid) begin
            if (!opc_ok)                      v_d.cause = CAUSE_OPC;
            else if (!zero_ok)                v_d.cause = CAUSE_ZERO;
            else if (!(&dt_gen_ok) || !dt_cls_ok) v_d.cause = CAUSE_DTYPE;
            else if (!oper_ok)                v_d.cause = CAUSE_OPER;
            else if (!lanes_ok)               v_d.cause = CAUSE_LANES;
            else if (!axis_ok)                v_d.cause = CAUSE_AXIS;
            else                              v_d.cause = CAUSE_NONE;
            v_d.accept = (v_d.cause == CAUSE_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '{accept: 1'b0, cause: CAUSE_NONE};
        else        v_q <= v_d;
    end

    assign accept   = v_q.accept;
    assign err_code = v_q.cause;

    // R11: outputs stay put while no strobe is present
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_valid |=> $stable(accept) && $stable(err_code));

    // R11: an accepted descriptor never carries a cause
    a_r11_accept_clean: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> err_code == 3'd0);

    // R1: a foreign opcode is refused with the opcode cause
    a_r1_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_data[7:0] != OPC_ARITH && desc_data[7:0] != OPC_BITW
        |=> !accept && err_code == 3'd1);

    // R2: a set negate byte on a known opcode yields the zero-field cause
    a_r2_negate: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && (desc_data[7:0] == OPC_ARITH || desc_data[7:0] == OPC_BITW) &&
        desc_data[OFF_NEG*8 +: 8] != 8'h00
        |=> !accept && err_code == 3'd2);

    // R8: a clean-looking descriptor with zero lanes can never be accepted
    a_r8_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_data[OFF_LANES*8 +: 8] == 8'h00 |=> !accept);
endmodule

// File: tb/sim_scan_desc_check.sv
`timescale 1ns/1ps
module sim_scan_desc_check;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         desc_valid = 1'b0;
    logic [511:0] desc_data = '0;
    logic         accept;
    logic [2:0]   err_code;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    scan_desc_check u0 (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid),
        .desc_data(desc_data), .accept(accept), .err_code(err_code)
    );

    typedef struct {
        logic [7:0] opc, din, dout, lanes, neg, oper, axis, mask;
        int         rsv_idx;
        logic [7:0] rsv_val;
    } fld_t;

    function automatic fld_t base_arith();
        fld_t f;
        f.opc = 8'h4E; f.din = 8'h0A; f.dout = 8'h0A; f.lanes = 8'd16;
        f.neg = 8'h00; f.oper = 8'h01; f.axis = 8'h00; f.mask = 8'h00;
        f.rsv_idx = 39; f.rsv_val = 8'h00;
        return f;
    endfunction

    function automatic fld_t base_bitw();
        fld_t f = base_arith();
        f.opc = 8'h5E; f.din = 8'h09; f.dout = 8'h09; f.oper = 8'h27;
        return f;
    endfunction

    function automatic logic [511:0] pack(fld_t f);
        logic [511:0] d = '0;
        for (int k = 1; k < 64; k++) d[k*8 +: 8] = 8'(k * 7);
        for (int k = 39; k <= 43; k++) d[k*8 +: 8] = 8'h00;
        d[0 +: 8] = f.opc;      d[32*8 +: 8] = f.din; d[33*8 +: 8] = f.dout;
        d[34*8 +: 8] = f.lanes; d[35*8 +: 8] = f.neg; d[36*8 +: 8] = f.oper;
        d[37*8 +: 8] = f.axis;  d[38*8 +: 8] = f.mask;
        d[f.rsv_idx*8 +: 8] = f.rsv_val;
        return d;
    endfunction

    task automatic check(string req, logic exp_acc, logic [2:0] exp_err);
        n_run++;
        if (accept !== exp_acc || err_code !== exp_err) begin
            n_fail++;
            $display("FAIL %s: accept=%0b err=%0d expected accept=%0b err=%0d",
                     req, accept, err_code, exp_acc, exp_err);
        end
    endtask

    task automatic judge(fld_t f, string req, logic exp_acc, logic [2:0] exp_err);
        @(negedge clk);
        desc_data  = pack(f);
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        check(req, exp_acc, exp_err);
    endtask

    task automatic t_reset();
        check("R11 reset", 1'b0, 3'd0);
    endtask

    task automatic t_legal();
        fld_t f = base_arith();
        judge(f, "R5 arith add fp32", 1'b1, 3'd0);
        f = base_bitw();
        judge(f, "R6 bitwise xor u32", 1'b1, 3'd0);
        f = base_arith(); f.dout = 8'h0B;
        judge(f, "R3 fp32r output", 1'b1, 3'd0);
        f = base_arith(); f.oper = 8'h1D;
        judge(f, "R5 rsqrt", 1'b1, 3'd0);
        f = base_arith(); f.oper = 8'hC8; f.din = 8'h08; f.dout = 8'h08;
        judge(f, "R5 int band top", 1'b1, 3'd0);
        f = base_arith(); f.lanes = 8'd128; f.axis = 8'h03;
        judge(f, "R8 128 lanes axis 3", 1'b1, 3'd0);
        f = base_bitw(); f.oper = 8'h24; f.din = 8'h08; f.dout = 8'h08;
        judge(f, "R7 lsr on int32", 1'b1, 3'd0);
        f = base_bitw(); f.oper = 8'h1C; f.din = 8'h03; f.dout = 8'h03;
        judge(f, "R6 crc u8", 1'b1, 3'd0);
    endtask

    task automatic t_opcode();
        fld_t f = base_arith(); f.opc = 8'h4F;
        judge(f, "R1 opcode 0x4F", 1'b0, 3'd1);
        f.opc = 8'h42;
        judge(f, "R1 opcode 0x42", 1'b0, 3'd1);
    endtask

    task automatic t_zero();
        fld_t f = base_arith(); f.neg = 8'h01;
        judge(f, "R2 negate", 1'b0, 3'd2);
        f = base_bitw(); f.mask = 8'h80;
        judge(f, "R2 mask", 1'b0, 3'd2);
        f = base_arith(); f.rsv_idx = 43; f.rsv_val = 8'h10;
        judge(f, "R2 reserved 43", 1'b0, 3'd2);
    endtask

    task automatic t_dtype();
        fld_t f = base_arith(); f.din = 8'h0B;
        judge(f, "R3 fp32r input", 1'b0, 3'd3);
        f = base_arith(); f.dout = 8'h0C;
        judge(f, "R3 int64 out", 1'b0, 3'd3);
        f = base_arith(); f.din = 8'h01;
        judge(f, "R3 uint64 in", 1'b0, 3'd3);
        f = base_bitw(); f.dout = 8'h05;
        judge(f, "R4 bitwise type mismatch", 1'b0, 3'd3);
        f = base_bitw(); f.din = 8'h0A; f.dout = 8'h0A;
        judge(f, "R4 bitwise fp32", 1'b0, 3'd3);
    endtask

    task automatic t_oper();
        fld_t f = base_arith(); f.oper = 8'h07;
        judge(f, "R5 divide", 1'b0, 3'd4);
        f.oper = 8'h1C;
        judge(f, "R5 crc in arith", 1'b0, 3'd4);
        f = base_bitw(); f.oper = 8'h1B;
        judge(f, "R6 mod in bitwise", 1'b0, 3'd4);
        f.oper = 8'h01;
        judge(f, "R6 add in bitwise", 1'b0, 3'd4);
        f = base_bitw(); f.oper = 8'h24;
        judge(f, "R7 lsr on u32", 1'b0, 3'd4);
    endtask

    task automatic t_lanes_axis();
        fld_t f = base_arith(); f.lanes = 8'd0;
        judge(f, "R8 zero lanes", 1'b0, 3'd5);
        f.lanes = 8'd129;
        judge(f, "R8 129 lanes", 1'b0, 3'd5);
        f = base_arith(); f.axis = 8'h04;
        judge(f, "R9 axis 4", 1'b0, 3'd6);
    endtask

    task automatic t_priority();
        fld_t f = base_arith(); f.opc = 8'h00; f.rsv_idx = 40; f.rsv_val = 8'h01;
        judge(f, "R10 opcode over zero", 1'b0, 3'd1);
        f = base_arith(); f.oper = 8'h1A; f.lanes = 8'd0;
        judge(f, "R10 operator over lanes", 1'b0, 3'd4);
        f = base_arith(); f.neg = 8'h02; f.din = 8'h00;
        judge(f, "R10 zero over dtype", 1'b0, 3'd2);
        f = base_bitw(); f.dout = 8'h03; f.oper = 8'h07; f.axis = 8'h09;
        judge(f, "R10 dtype over operator", 1'b0, 3'd3);
    endtask

    task automatic t_hold();
        fld_t f = base_arith(); f.axis = 8'h05;
        judge(f, "R9 axis 5", 1'b0, 3'd6);
        f = base_arith();
        @(negedge clk);
        desc_data = pack(f);
        repeat (3) @(negedge clk);
        check("R11 hold without strobe", 1'b0, 3'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_legal();
        t_opcode();
        t_zero();
        t_dtype();
        t_oper();
        t_lanes_axis();
        t_priority();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule